// File: doc/BRIEF.md
# BCD calendar clock with snapshot registers

This block is a real-time clock core that keeps seconds, minutes, hours, day of week, date, month and a two-digit year as packed BCD bytes. Each field holds its tens digit in the upper bits and its units digit in the low nibble. A single-cycle pulse on `tick` advances the count by one second. Software reaches the clock through a window of 16 byte-wide registers. The window has an address, a write strobe, write data and combinational read data.

The block holds two copies of the time. The internal copy counts. The visible copy is the one that software reads, and it normally follows the internal copy. A freeze bit in the control register holds the visible copy still, so that a multi-byte read is coherent while counting carries on underneath. A write bit redirects time writes into the visible copy only; when that bit clears, all seven fields move into the counter in one cycle. A stop bit in the seconds byte gates all counting.

Register offsets: 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month, 6 year, 7 control, 8 to 14 plain storage bytes, 15 flags. The bits of the time registers that lie above the BCD digits are spare storage bits. This includes bit 6 of the day register, which serves as a test-output enable bit and nothing more.

Top module: `rtc_bcd_core`

## Requirements
- R1: After reset, seconds reads 0x80 (stop bit set), minutes 0x00, hours 0x00, day 0x01, date 0x01, month 0x01, year 0x00, control 0x00 and flags 0x00.
- R2: Bit 7 of seconds (offset 0) is the stop bit. While it is 1, no tick changes any count. While it is 0, each tick advances the count by one second.
- R3: Seconds and minutes count in BCD from 00 to 59 and hours from 00 to 23. The units digit carries into the tens digit after 9, and each field wraps to 00 and carries into the next field.
- R4: When hours wrap, the date advances and wraps to 01 after the last day of the month (30 for months 04, 06, 09 and 11, 31 for the other months except February). Day of week advances at the same time and wraps from 07 to 01.
- R5: February has 29 days when the year value is divisible by 4 (00 included) and 28 days otherwise.
- R6: Month wraps from 12 to 01 and carries into the year; the year wraps from 99 to 00.
- R7: Setting bit 6 of control (offset 7) freezes the visible time registers at the count present in the cycle the bit was written, and the internal count keeps advancing while it is frozen.
- R8: Once bit 6 of control is cleared, the visible registers show the internal count no later than after the next tick.
- R9: While bit 7 of control is 1, time writes land only in the visible registers and the counter is untouched. Writing control with bit 7 at 0 copies all seven visible fields into the counter in one cycle.
- R10: With bit 7 of control at 0, a write to a time register goes straight into the counter and is readable from the next cycle on (when not frozen).
- R11: In flags (offset 15), bits 5, 3, 2, 1 and 0 always read 0 and ignore writes. Bits 7, 6 and 4 are read/write.
- R12: Spare bits above the BCD digits of the time registers keep their written value through counting. Offsets 8 to 14 are plain read/write bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse, once per second |
| addr | input | ADDR_W | Register offset |
| wr_en | input | 1 | Write strobe for the addressed register |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data of the addressed register (combinational) |

## Verification
The bench goes after every carry boundary: units-to-tens digit carries, the 59 and 23 wraps, and month ends of 30, 31, 28 and 29 days, including year 00 and a non-leap year ending in 1. A design that treated the fields as binary would show 0x0A, and a wrong month table would produce a 31st of April or skip a leap day. The bench also checks that a frozen read holds while ticks arrive and that the released registers show the advanced count, which catches a freeze that stops the counter itself. It checks that staged writes stay out of the counter until the write bit drops, and that spare bits and the read-as-zero flag bits survive counting and writes. A design with a loose mask would change those bits.

// File: rtl/rtc_bcd_pkg.sv
package rtc_bcd_pkg;
   localparam int NFIELD    = 7;
   localparam int F_SEC     = 0;
   localparam int F_MIN     = 1;
   localparam int F_HOUR    = 2;
   localparam int F_DOW     = 3;
   localparam int F_DATE    = 4;
   localparam int F_MON     = 5;
   localparam int F_YEAR    = 6;
   localparam int CTRL_OFS  = 7;
   localparam int SPARE_OFS = 8;
   localparam int STOP_BIT  = 7;
   localparam int FRZ_BIT   = 6;
   localparam int STAGE_BIT = 7;
   localparam logic [7:0] FLAG_KEEP = 8'hD0;

   typedef logic [NFIELD-1:0][7:0] rtc_time_t;

   // digit bits of each field, year down to seconds
   localparam rtc_time_t DIGIT_MASK = {8'hFF, 8'h1F, 8'h3F, 8'h07, 8'h3F, 8'h7F, 8'h7F};

   // {wrapped, next byte}; bits outside mask are carried unchanged
   function automatic logic [8:0] bcd_step(input logic [7:0] v, input logic [7:0] mask,
                                           input logic [7:0] lo, input logic [7:0] hi);
      logic [7:0] d;
      logic [7:0] n;
      logic       w;
      d = v & mask;
      w = (d >= hi);
      if (w)
         n = lo;
      else if (d[3:0] >= 4'h9)
         n = {d[7:4] + 4'h1, 4'h0};
      else
         n = d + 8'h01;
      return {w, (v & ~mask) | (n & mask)};
   endfunction

   function automatic logic [7:0] month_len(input logic [7:0] mon, input logic [7:0] yr);
      logic [4:0] m4;
      logic       leap;
      logic [7:0] len;
      m4   = {yr[7:4], 1'b0} + {1'b0, yr[3:0]};
      leap = (m4[1:0] == 2'b00);
      case (mon & 8'h1F)
         8'h02:                      len = leap ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: len = 8'h30;
         default:                    len = 8'h31;
      endcase
      return len;
   endfunction
endpackage

// File: rtl/rtc_advance.sv
module rtc_advance
   import rtc_bcd_pkg::*;
(
   input  rtc_time_t cur,
   input  logic      step,
   output rtc_time_t nxt
);
   logic [8:0] r_sec, r_min, r_hour, r_dow, r_date, r_mon, r_year;
   logic       c_min, c_hour, c_day, c_mon, c_year;

   always_comb begin
      r_sec  = bcd_step(cur[F_SEC],  DIGIT_MASK[F_SEC],  8'h00, 8'h59);
      r_min  = bcd_step(cur[F_MIN],  DIGIT_MASK[F_MIN],  8'h00, 8'h59);
      r_hour = bcd_step(cur[F_HOUR], DIGIT_MASK[F_HOUR], 8'h00, 8'h23);
      r_dow  = bcd_step(cur[F_DOW],  DIGIT_MASK[F_DOW],  8'h01, 8'h07);
      r_date = bcd_step(cur[F_DATE], DIGIT_MASK[F_DATE], 8'h01,
                        month_len(cur[F_MON], cur[F_YEAR]));
      r_mon  = bcd_step(cur[F_MON],  DIGIT_MASK[F_MON],  8'h01, 8'h12);
      r_year = bcd_step(cur[F_YEAR], DIGIT_MASK[F_YEAR], 8'h00, 8'h99);

      c_min  = step   & r_sec[8];
      c_hour = c_min  & r_min[8];
      c_day  = c_hour & r_hour[8];
      c_mon  = c_day  & r_date[8];
      c_year = c_mon  & r_mon[8];

      nxt         = cur;
      nxt[F_SEC]  = step   ? r_sec[7:0]  : cur[F_SEC];
      nxt[F_MIN]  = c_min  ? r_min[7:0]  : cur[F_MIN];
      nxt[F_HOUR] = c_hour ? r_hour[7:0] : cur[F_HOUR];
      nxt[F_DOW]  = c_day  ? r_dow[7:0]  : cur[F_DOW];
      nxt[F_DATE] = c_day  ? r_date[7:0] : cur[F_DATE];
      nxt[F_MON]  = c_mon  ? r_mon[7:0]  : cur[F_MON];
      nxt[F_YEAR] = c_year ? r_year[7:0] : cur[F_YEAR];
   end
endmodule

// File: rtl/rtc_counter.sv
module rtc_counter
   import rtc_bcd_pkg::*;
#(
   parameter rtc_time_t INIT = '0
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       load,
   input  rtc_time_t  load_val,
   input  logic       fld_we,
   input  logic [2:0] fld_idx,
   input  logic [7:0] fld_data,
   output rtc_time_t  cnt
);
   rtc_time_t nxt;
   logic      step;

   assign step = tick & ~cnt[F_SEC][STOP_BIT];

   rtc_advance u_adv (
      .cur  (cnt),
      .step (step),
      .nxt  (nxt)
   );

   // a bulk load or a direct field write takes the cycle; a tick there is dropped
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= INIT;
      else if (load)
         cnt <= load_val;
      else if (fld_we)
         cnt[fld_idx] <= fld_data;
      else
         cnt <= nxt;
   end
endmodule

// File: rtl/rtc_regs.sv
module rtc_regs
   import rtc_bcd_pkg::*;
#(
   parameter int        ADDR_W = 4,
   parameter rtc_time_t INIT   = '0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [7:0]        wr_data,
   input  rtc_time_t         cnt,
   output logic [7:0]        rd_data,
   output rtc_time_t         vis,
   output logic              rbit_q,
   output logic              wbit_q,
   output logic              load,
   output logic              fld_we,
   output logic [2:0]        fld_idx,
   output logic [7:0]        fld_data
);
   localparam int NREG     = 2 ** ADDR_W;
   localparam int FLAG_OFS = NREG - 1;
   localparam int N_SPARE  = NREG - SPARE_OFS - 1;
   localparam int SP_W     = (N_SPARE > 1) ? $clog2(N_SPARE) : 1;

   logic [7:0]        ctrl_q;
   logic [7:0]        flag_q;
   logic [7:0]        spare_q [N_SPARE];
   logic              is_time, is_ctrl, is_flag;
   logic [ADDR_W-1:0] sp_off;

   assign is_time  = (addr < ADDR_W'(NFIELD));
   assign is_ctrl  = (addr == ADDR_W'(CTRL_OFS));
   assign is_flag  = (addr == ADDR_W'(FLAG_OFS));
   assign rbit_q   = ctrl_q[FRZ_BIT];
   assign wbit_q   = ctrl_q[STAGE_BIT];
   assign fld_we   = wr_en & is_time & ~wbit_q;
   assign fld_idx  = addr[2:0];
   assign fld_data = wr_data;
   assign load     = wr_en & is_ctrl & ~wr_data[STAGE_BIT] & wbit_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         flag_q <= '0;
      end else if (wr_en) begin
         if (is_ctrl) ctrl_q <= wr_data;
         if (is_flag) flag_q <= wr_data & FLAG_KEEP;
      end
   end

   // visible set: staged writes while staging, else mirror unless frozen
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         vis <= INIT;
      else if (wbit_q) begin
         if (wr_en && is_time) vis[addr[2:0]] <= wr_data;
      end else if (!rbit_q)
         vis <= cnt;
   end

   for (genvar g = 0; g < N_SPARE; g++) begin : g_spare
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            spare_q[g] <= '0;
         else if (wr_en && addr == ADDR_W'(SPARE_OFS + g))
            spare_q[g] <= wr_data;
      end
   end

   always_comb begin
      sp_off = addr - ADDR_W'(SPARE_OFS);
      if (is_time)
         rd_data = vis[addr[2:0]];
      else if (is_ctrl)
         rd_data = ctrl_q;
      else if (is_flag)
         rd_data = flag_q;
      else
         rd_data = spare_q[sp_off[SP_W-1:0]];
   end
endmodule

// File: rtl/rtc_bcd_core.sv
module rtc_bcd_core
   import rtc_bcd_pkg::*;
#(
   parameter int ADDR_W        = 4,
   parameter bit START_STOPPED = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [7:0]        wr_data,
   output logic [7:0]        rd_data
);
   localparam logic [7:0] INIT_SEC  = START_STOPPED ? 8'h80 : 8'h00;
   localparam rtc_time_t  INIT_TIME = {8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, INIT_SEC};

   if (ADDR_W < 4) begin : g_bad_addr
      $error("rtc_bcd_core: ADDR_W must be at least 4");
   end

   rtc_time_t  cnt;
   rtc_time_t  vis;
   logic       rbit_q, wbit_q, load, fld_we;
   logic [2:0] fld_idx;
   logic [7:0] fld_data;

   rtc_regs #(.ADDR_W(ADDR_W), .INIT(INIT_TIME)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .addr     (addr),
      .wr_en    (wr_en),
      .wr_data  (wr_data),
      .cnt      (cnt),
      .rd_data  (rd_data),
      .vis      (vis),
      .rbit_q   (rbit_q),
      .wbit_q   (wbit_q),
      .load     (load),
      .fld_we   (fld_we),
      .fld_idx  (fld_idx),
      .fld_data (fld_data)
   );

   rtc_counter #(.INIT(INIT_TIME)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .load     (load),
      .load_val (vis),
      .fld_we   (fld_we),
      .fld_idx  (fld_idx),
      .fld_data (fld_data),
      .cnt      (cnt)
   );
endmodule

// File: rtl/rtc_bcd_chk.sv
module rtc_bcd_chk
   import rtc_bcd_pkg::*;
#(
   parameter int ADDR_W = 4
)(
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] addr,
   input logic              wr_en,
   input logic [7:0]        rd_data,
   input rtc_time_t         cnt,
   input rtc_time_t         vis,
   input logic              rbit,
   input logic              wbit,
   input logic              load
);
   localparam int FLAG_OFS = 2 ** ADDR_W - 1;

   // R2
   stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt[F_SEC][STOP_BIT] && !wr_en) |=> $stable(cnt));

   // R7
   freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rbit && !wr_en) |=> $stable(vis));

   // R8
   track_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rbit && !wbit && !wr_en) |=> (vis == $past(cnt)));

   // R9
   xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (cnt == $past(vis)));

   // R11
   flag_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == ADDR_W'(FLAG_OFS)) |-> ((rd_data & 8'h2F) == 8'h00));
endmodule

bind rtc_bcd_core rtc_bcd_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .addr    (addr),
   .wr_en   (wr_en),
   .rd_data (rd_data),
   .cnt     (cnt),
   .vis     (vis),
   .rbit    (rbit_q),
   .wbit    (wbit_q),
   .load    (load)
);

// File: tb/sim_rtc_bcd_core.sv
module sim_rtc_bcd_core;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic [3:0] addr = '0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   rtc_bcd_core u0 (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .addr    (addr),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .rd_data (rd_data)
   );

   // {start time, time after one tick}; each {yr,mon,date,dow,hour,min,sec}
   localparam logic [111:0] VEC [16] = '{
      {56'h00_01_01_01_00_00_00, 56'h00_01_01_01_00_00_01},
      {56'h00_01_01_01_00_00_09, 56'h00_01_01_01_00_00_10},
      {56'h00_01_01_01_00_00_59, 56'h00_01_01_01_00_01_00},
      {56'h00_01_01_01_09_59_59, 56'h00_01_01_01_10_00_00},
      {56'h99_12_31_07_23_59_59, 56'h00_01_01_01_00_00_00},
      {56'h23_02_28_03_23_59_59, 56'h23_03_01_04_00_00_00},
      {56'h24_02_28_03_23_59_59, 56'h24_02_29_04_00_00_00},
      {56'h24_02_29_04_23_59_59, 56'h24_03_01_05_00_00_00},
      {56'h25_04_30_02_23_59_59, 56'h25_05_01_03_00_00_00},
      {56'h19_01_31_05_23_59_59, 56'h19_02_01_06_00_00_00},
      {56'h49_12_31_06_23_59_59, 56'h50_01_01_07_00_00_00},
      {56'h25_09_30_01_23_59_59, 56'h25_10_01_02_00_00_00},
      {56'h00_02_28_02_23_59_59, 56'h00_02_29_03_00_00_00},
      {56'h30_07_04_04_12_39_59, 56'h30_07_04_04_12_40_00},
      {56'h31_02_28_01_23_59_59, 56'h31_03_01_02_00_00_00},
      {56'h26_11_30_07_19_59_59, 56'h26_11_30_07_20_00_00}
   };

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [7:0] d);
      @(negedge clk);
      addr = a;
      #1 d = rd_data;
   endtask

   task automatic pulse();
      @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
   endtask

   task automatic set_time(input logic [55:0] t);
      wr(4'd7, 8'h80);
      for (int i = 0; i < 7; i++) wr(i[3:0], t[i*8 +: 8]);
      wr(4'd7, 8'h00);
   endtask

   task automatic get_time(output logic [55:0] t);
      logic [7:0] b;
      for (int i = 0; i < 7; i++) begin
         rd(i[3:0], b);
         t[i*8 +: 8] = b;
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", checks - fails, checks);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog (R1..R12 run) actual=hung expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      logic [55:0] t;
      logic [7:0]  b;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      get_time(t);
      chk("R1 time after reset", {8'h0, t}, {8'h0, 56'h00_01_01_01_00_00_80});
      rd(4'd7, b);  chk("R1 control after reset", {56'h0, b}, 64'h00);
      rd(4'd15, b); chk("R1 flags after reset", {56'h0, b}, 64'h00);

      // R2 stopped after reset
      repeat (3) pulse();
      rd(4'd0, b); chk("R2 no count while stopped", {56'h0, b}, 64'h80);

      // R3 R4 R5 R6 rollover table
      for (int k = 0; k < 16; k++) begin
         set_time(VEC[k][111:56]);
         pulse();
         get_time(t);
         chk($sformatf("R3/R4/R5/R6 vector %0d", k), {8'h0, t}, {8'h0, VEC[k][55:0]});
      end

      // R7 freeze, R8 release
      set_time(56'h25_06_15_03_10_20_30);
      wr(4'd7, 8'h40);
      repeat (5) pulse();
      get_time(t);
      chk("R7 visible frozen", {8'h0, t}, {8'h0, 56'h25_06_15_03_10_20_30});
      wr(4'd7, 8'h00);
      pulse();
      rd(4'd0, b); chk("R8 tracking after release", {56'h0, b}, 64'h36);

      // R10 direct write, R2 stop then run
      wr(4'd1, 8'h15);
      rd(4'd1, b); chk("R10 direct minute write", {56'h0, b}, 64'h15);
      wr(4'd0, 8'hC5);
      repeat (2) pulse();
      rd(4'd0, b); chk("R2 stop bit holds count", {56'h0, b}, 64'hC5);
      wr(4'd0, 8'h45);
      pulse();
      rd(4'd0, b); chk("R2 running after clear", {56'h0, b}, 64'h46);

      // R9 staged write
      wr(4'd7, 8'h80);
      wr(4'd0, 8'h12);
      rd(4'd0, b); chk("R9 staged value visible", {56'h0, b}, 64'h12);
      repeat (2) pulse();
      rd(4'd0, b); chk("R9 visible held while staging", {56'h0, b}, 64'h12);
      wr(4'd7, 8'h00);
      rd(4'd0, b); chk("R9 transfer on clear", {56'h0, b}, 64'h12);
      pulse();
      rd(4'd0, b); chk("R9 counting from loaded value", {56'h0, b}, 64'h13);

      // R12 spare bits through rollover and plain bytes
      set_time(56'h25_03_10_47_A3_59_59);
      pulse();
      get_time(t);
      chk("R12 spare bits across rollover", {8'h0, t}, {8'h0, 56'h25_03_11_41_80_00_00});
      wr(4'd9, 8'hA5);
      wr(4'd14, 8'h3C);
      rd(4'd9, b);  chk("R12 plain byte 9", {56'h0, b}, 64'hA5);
      rd(4'd14, b); chk("R12 plain byte 14", {56'h0, b}, 64'h3C);

      // R11 flags
      wr(4'd15, 8'hFF);
      rd(4'd15, b); chk("R11 flags read-zero bits", {56'h0, b}, 64'hD0);
      wr(4'd15, 8'h00);
      rd(4'd15, b); chk("R11 flags cleared", {56'h0, b}, 64'h00);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule